// File: doc/BRIEF.md
# Configurable Priority Candidate Sorter

The sorter receives a group of track trigger candidates in the same clock cycle and reports which one has the highest priority. For every candidate it builds a 15-bit priority key. The key starts at all ones, and clearing a bit raises priority, so the numerically smallest key wins. In normal mode the key holds the track-order bit, three quality bits and the 5-bit bending value. The position of each quality bit within the key is chosen at run time, and each quality flag can be switched on or off through its own enable.

There are three enable sets: one for first tracks, one for second tracks, and a dedicated set for carried candidates. A separate back-up mode ignores the bending value and the quality flags. In that mode the key is built from a 3-bit trigger code.

The winner's index and key, together with a flag that says whether any candidate was present, are registered one clock after the inputs are sampled.

Top module: `prio_cand_sorter`

## Requirements
- R1: While rst_ni is low, win_valid_o is 0, win_idx_o is 0 and win_key_o is 0x7FFF.
- R2: The outputs update at the clock edge that samples the inputs. win_valid_o is 1 exactly when at least one cand_valid_i bit was 1.
- R3: The winner is the valid candidate with the numerically smallest key. Among equal keys, the lowest index wins. An invalid candidate never wins while any candidate is valid.
- R4: In a valid candidate's key, bit 14 equals cand_second_i (0 = first track, 1 = second track), and bits 13..8 are always 1.
- R5: In normal mode, a valid candidate with cand_k_i (6 bits) of 31 or less has key bits 4..0 equal to that value. A value of 32 or more leaves key bits 13..0 all ones.
- R6: order_sel_i places the quality bits at key bits 7, 6 and 5. The codes are: 0 = high, inner, corr; 1 = high, corr, inner; 2 = inner, high, corr; 3 = inner, corr, high; 4 = corr, high, inner; 5 = corr, inner, high. Each code lists the flags from bit 7 down to bit 5.
- R7: With order_sel_i equal to 6 or 7, key bits 7..5 stay at 1, and the bending value is still loaded.
- R8: A quality bit is cleared only when its flag is 1 and its enable is 1. Enable vectors use bit 0 for high, bit 1 for inner and bit 2 for corr. Non-carry candidates take en_second_i when cand_second_i is 1 and en_first_i otherwise.
- R9: A candidate with cand_carry_i set takes en_carry_i in place of the track enables.
- R10: In back-up mode, key bits 6..4 come from cand_code_i: 6 gives 000, 5 gives 001, 4 gives 010, 3 gives 101, 2 gives 100, 0 gives 110, and any other code gives 111. Key bits 13..7 and 3..0 stay at 1.
- R11: An invalid candidate's key is 0x7FFF. When no candidate is valid, the outputs are valid 0, index 0 and key 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bkup_mode_i | input | 1 | 1 selects back-up key building |
| order_sel_i | input | 3 | Quality bit ordering code |
| en_first_i | input | 3 | Flag enables for first tracks |
| en_second_i | input | 3 | Flag enables for second tracks |
| en_carry_i | input | 3 | Flag enables for carried candidates |
| cand_valid_i | input | N_CAND | Candidate present |
| cand_second_i | input | N_CAND | Second-track marker |
| cand_carry_i | input | N_CAND | Carry marker |
| cand_high_i | input | N_CAND | High-quality flag |
| cand_inner_i | input | N_CAND | Inner-layer flag |
| cand_corr_i | input | N_CAND | Correlated flag |
| cand_k_i | input | 6*N_CAND | Bending value per candidate (slot i at bits 6i+5..6i) |
| cand_code_i | input | 3*N_CAND | Trigger code per candidate (slot i at bits 3i+2..3i) |
| win_valid_o | output | 1 | Any candidate valid |
| win_idx_o | output | clog2(N_CAND) | Winning slot |
| win_key_o | output | 15 | Winning key |

## Verification
Two enable selections can act on the same candidate in the same cycle: the carry override and the selection by track order. Both are provoked together by a sweep over every combination of carry, track, flags and ordering code. In that sweep, the enable set that should apply gets a swept value and the other two sets get its complement, so picking the wrong set changes the key. Arbitration is exercised at the same time by random groups drawn from a small value range, which makes exact key ties frequent. The reported index is judged against a reference arbitration that takes the lowest index on a tie.

// File: rtl/cand_sort_pkg.sv
package cand_sort_pkg;
  localparam int KEY_W   = 15;
  localparam int K_W     = 5;
  localparam int K_IN_W  = K_W + 1;
  localparam int CODE_W  = 3;
  localparam int NFLAG   = 3;
  localparam int TRK_BIT = KEY_W - 1;
  localparam int QLO_BIT = 5;           // quality field is key[7:5]
  localparam int QHI_BIT = QLO_BIT + NFLAG - 1;
  localparam int BK_LO   = 4;           // back-up field is key[6:4]

  typedef logic [KEY_W-1:0] key_t;
  typedef logic [NFLAG-1:0] qmask_t;    // bit2 -> key[7], bit0 -> key[5]

  // enable / flag vector layout
  localparam int F_HIGH  = 0;
  localparam int F_INNER = 1;
  localparam int F_CORR  = 2;
endpackage

// File: rtl/csort_order_dec.sv
module csort_order_dec
  import cand_sort_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] order_sel_i,
  output qmask_t     pos_high_o,
  output qmask_t     pos_inner_o,
  output qmask_t     pos_corr_o,
  output logic       legal_o
);
  always_comb begin
    legal_o     = 1'b1;
    pos_high_o  = '0;
    pos_inner_o = '0;
    pos_corr_o  = '0;
    unique case (order_sel_i)
      3'd0: begin pos_high_o = 3'b100; pos_inner_o = 3'b010; pos_corr_o = 3'b001; end
      3'd1: begin pos_high_o = 3'b100; pos_corr_o  = 3'b010; pos_inner_o = 3'b001; end
      3'd2: begin pos_inner_o = 3'b100; pos_high_o = 3'b010; pos_corr_o = 3'b001; end
      3'd3: begin pos_inner_o = 3'b100; pos_corr_o = 3'b010; pos_high_o = 3'b001; end
      3'd4: begin pos_corr_o = 3'b100; pos_high_o  = 3'b010; pos_inner_o = 3'b001; end
      3'd5: begin pos_corr_o = 3'b100; pos_inner_o = 3'b010; pos_high_o = 3'b001; end
      default: legal_o = 1'b0;
    endcase
  end

  AST_PERM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_o |-> ((pos_high_o | pos_inner_o | pos_corr_o) == 3'b111)
                && $onehot0(pos_high_o) && $onehot0(pos_inner_o)); // R6
  AST_PERM_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_o |-> ((pos_high_o | pos_inner_o | pos_corr_o) == 3'b000)); // R7
endmodule

// File: rtl/csort_key_build.sv
module csort_key_build
  import cand_sort_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bkup_i,
  input  qmask_t            pos_high_i,
  input  qmask_t            pos_inner_i,
  input  qmask_t            pos_corr_i,
  input  logic              legal_i,
  input  logic [NFLAG-1:0]  en_first_i,
  input  logic [NFLAG-1:0]  en_second_i,
  input  logic [NFLAG-1:0]  en_carry_i,
  input  logic              valid_i,
  input  logic              second_i,
  input  logic              carry_i,
  input  logic              high_i,
  input  logic              inner_i,
  input  logic              corr_i,
  input  logic [K_IN_W-1:0] k_i,
  input  logic [CODE_W-1:0] code_i,
  output key_t              key_o
);
  logic [NFLAG-1:0] en_sel;
  qmask_t           qclr;
  logic             k_ok;

  assign en_sel = carry_i ? en_carry_i : (second_i ? en_second_i : en_first_i);
  assign k_ok   = (k_i[K_IN_W-1] == 1'b0);

  always_comb begin
    qclr = '0;
    if (legal_i) begin
      if (high_i  && en_sel[F_HIGH])  qclr = qclr | pos_high_i;
      if (inner_i && en_sel[F_INNER]) qclr = qclr | pos_inner_i;
      if (corr_i  && en_sel[F_CORR])  qclr = qclr | pos_corr_i;
    end
  end

  always_comb begin
    key_o = '1;
    if (valid_i) begin
      key_o[TRK_BIT] = second_i;
      if (bkup_i) begin
        unique case (code_i)
          3'd6:    key_o[BK_LO+2:BK_LO] = 3'b000;
          3'd5:    key_o[BK_LO+2:BK_LO] = 3'b001;
          3'd4:    key_o[BK_LO+2:BK_LO] = 3'b010;
          3'd3:    key_o[BK_LO+2:BK_LO] = 3'b101;
          3'd2:    key_o[BK_LO+2:BK_LO] = 3'b100;
          3'd0:    key_o[BK_LO+2:BK_LO] = 3'b110;
          default: key_o[BK_LO+2:BK_LO] = 3'b111;
        endcase
      end else if (k_ok) begin
        key_o[K_W-1:0]         = k_i[K_W-1:0];
        key_o[QHI_BIT:QLO_BIT] = ~qclr;
      end
    end
  end

  AST_INVALID_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (key_o == '1)); // R11
  AST_FILL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (key_o[TRK_BIT] == second_i) && (key_o[TRK_BIT-1:QHI_BIT+1] == '1)); // R4
  AST_K_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bkup_i && k_i[K_IN_W-1]) |-> (key_o[TRK_BIT-1:0] == '1)); // R5
  AST_ORDER_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bkup_i && !legal_i) |-> (key_o[QHI_BIT:QLO_BIT] == '1)); // R7
  AST_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bkup_i && en_sel == '0) |-> (key_o[QHI_BIT:QLO_BIT] == '1)); // R8
  AST_BK_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bkup_i) |-> (key_o[BK_LO-1:0] == '1) && key_o[QHI_BIT]); // R10
endmodule

// File: rtl/csort_argmin.sv
module csort_argmin
  import cand_sort_pkg::*;
#(
  parameter int N_CAND = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  key_t              keys_i [N_CAND],
  input  logic [N_CAND-1:0] valid_i,
  output key_t              best_key_o,
  output logic [IDX_W-1:0]  best_idx_o,
  output logic              any_valid_o
);
  // rank = {invalid, key}; strict less-than keeps the lower index on ties
  logic [KEY_W:0]   acc_rank [N_CAND];
  logic [IDX_W-1:0] acc_idx  [N_CAND];

  for (genvar i = 0; i < N_CAND; i++) begin : g_chain
    logic [KEY_W:0] rank;
    assign rank = {~valid_i[i], keys_i[i]};
    if (i == 0) begin : g_first
      assign acc_rank[i] = rank;
      assign acc_idx[i]  = '0;
    end else begin : g_next
      logic take;
      assign take        = rank < acc_rank[i-1];
      assign acc_rank[i] = take ? rank : acc_rank[i-1];
      assign acc_idx[i]  = take ? IDX_W'(i) : acc_idx[i-1];
    end
  end

  assign best_key_o  = acc_rank[N_CAND-1][KEY_W-1:0];
  assign best_idx_o  = acc_idx[N_CAND-1];
  assign any_valid_o = |valid_i;

  for (genvar i = 0; i < N_CAND; i++) begin : g_chk
    AST_MIN_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i[i] |-> (best_key_o <= keys_i[i])); // R3
    AST_TIE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[i] && keys_i[i] == best_key_o) |-> (best_idx_o <= IDX_W'(i))); // R3
  end
endmodule

// File: rtl/prio_cand_sorter.sv
module prio_cand_sorter
  import cand_sort_pkg::*;
#(
  parameter int N_CAND = 4,
  localparam int IDX_W = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bkup_mode_i,
  input  logic [2:0]               order_sel_i,
  input  logic [NFLAG-1:0]         en_first_i,
  input  logic [NFLAG-1:0]         en_second_i,
  input  logic [NFLAG-1:0]         en_carry_i,
  input  logic [N_CAND-1:0]        cand_valid_i,
  input  logic [N_CAND-1:0]        cand_second_i,
  input  logic [N_CAND-1:0]        cand_carry_i,
  input  logic [N_CAND-1:0]        cand_high_i,
  input  logic [N_CAND-1:0]        cand_inner_i,
  input  logic [N_CAND-1:0]        cand_corr_i,
  input  logic [N_CAND*K_IN_W-1:0] cand_k_i,
  input  logic [N_CAND*CODE_W-1:0] cand_code_i,
  output logic                     win_valid_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic [KEY_W-1:0]         win_key_o
);
  qmask_t           pos_high, pos_inner, pos_corr;
  logic             legal;
  key_t             keys [N_CAND];
  key_t             best_key;
  logic [IDX_W-1:0] best_idx;
  logic             any_valid;

  csort_order_dec u_order_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .order_sel_i (order_sel_i),
    .pos_high_o  (pos_high),
    .pos_inner_o (pos_inner),
    .pos_corr_o  (pos_corr),
    .legal_o     (legal)
  );

  for (genvar i = 0; i < N_CAND; i++) begin : g_key
    csort_key_build u_key (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bkup_i      (bkup_mode_i),
      .pos_high_i  (pos_high),
      .pos_inner_i (pos_inner),
      .pos_corr_i  (pos_corr),
      .legal_i     (legal),
      .en_first_i  (en_first_i),
      .en_second_i (en_second_i),
      .en_carry_i  (en_carry_i),
      .valid_i     (cand_valid_i[i]),
      .second_i    (cand_second_i[i]),
      .carry_i     (cand_carry_i[i]),
      .high_i      (cand_high_i[i]),
      .inner_i     (cand_inner_i[i]),
      .corr_i      (cand_corr_i[i]),
      .k_i         (cand_k_i[i*K_IN_W +: K_IN_W]),
      .code_i      (cand_code_i[i*CODE_W +: CODE_W]),
      .key_o       (keys[i])
    );
  end

  csort_argmin #(.N_CAND(N_CAND), .IDX_W(IDX_W)) u_argmin (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .keys_i      (keys),
    .valid_i     (cand_valid_i),
    .best_key_o  (best_key),
    .best_idx_o  (best_idx),
    .any_valid_o (any_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_o <= 1'b0;
      win_idx_o   <= '0;
      win_key_o   <= '1;
    end else begin
      win_valid_o <= any_valid;
      win_idx_o   <= best_idx;
      win_key_o   <= best_key;
    end
  end

  AST_OUT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (win_valid_o == $past(|cand_valid_i))); // R2
  AST_IDLE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_valid_o |-> (win_key_o == '1) && (win_idx_o == '0)); // R11
  AST_WIN_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (!win_valid_o || $past(cand_valid_i[best_idx]))); // R3
endmodule

// File: tb/prio_cand_sorter_bench.sv
module prio_cand_sorter_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic         bk;
  logic [2:0]   ord, ef, es, ec;
  logic [N-1:0] v, sec, car, hi, inn, cor;
  logic [N*6-1:0] kv;
  logic [N*3-1:0] code;
  logic         o_valid;
  logic [1:0]   o_idx;
  logic [14:0]  o_key;

  int n_cmp = 0;
  int n_bad = 0;
  logic         x_valid;
  logic [1:0]   x_idx;
  logic [14:0]  x_key;

  prio_cand_sorter #(.N_CAND(N)) u_prio_cand_sorter (
    .clk_i(clk), .rst_ni(rst_ni), .bkup_mode_i(bk), .order_sel_i(ord),
    .en_first_i(ef), .en_second_i(es), .en_carry_i(ec),
    .cand_valid_i(v), .cand_second_i(sec), .cand_carry_i(car),
    .cand_high_i(hi), .cand_inner_i(inn), .cand_corr_i(cor),
    .cand_k_i(kv), .cand_code_i(code),
    .win_valid_o(o_valid), .win_idx_o(o_idx), .win_key_o(o_key)
  );

  function automatic logic [14:0] ref_key(int s);
    logic [14:0] key;
    logic [2:0]  en;
    logic [5:0]  k;
    int ph, pn, pc;
    key = '1;
    if (!v[s]) return key;
    key[14] = sec[s];
    k = kv[s*6 +: 6];
    if (bk) begin
      case (code[s*3 +: 3])
        3'd6: key[6:4] = 3'b000;
        3'd5: key[6:4] = 3'b001;
        3'd4: key[6:4] = 3'b010;
        3'd3: key[6:4] = 3'b101;
        3'd2: key[6:4] = 3'b100;
        3'd0: key[6:4] = 3'b110;
        default: ;
      endcase
    end else if (k < 32) begin
      key[4:0] = k[4:0];
      en = car[s] ? ec : (sec[s] ? es : ef);
      case (ord)
        3'd0: begin ph = 7; pn = 6; pc = 5; end
        3'd1: begin ph = 7; pc = 6; pn = 5; end
        3'd2: begin pn = 7; ph = 6; pc = 5; end
        3'd3: begin pn = 7; pc = 6; ph = 5; end
        3'd4: begin pc = 7; ph = 6; pn = 5; end
        3'd5: begin pc = 7; pn = 6; ph = 5; end
        default: begin ph = -1; pn = -1; pc = -1; end
      endcase
      if (ph >= 0) begin
        if (hi[s]  && en[0]) key[ph] = 1'b0;
        if (inn[s] && en[1]) key[pn] = 1'b0;
        if (cor[s] && en[2]) key[pc] = 1'b0;
      end
    end
    return key;
  endfunction

  task automatic compute_exp();
    logic [15:0] best, r;
    best = {1'b1, 15'h7FFF};
    x_idx = 0;
    for (int s = 0; s < N; s++) begin
      r = {~v[s], ref_key(s)};
      if (r < best) begin best = r; x_idx = 2'(s); end
    end
    x_valid = |v;
    x_key = best[14:0];
  endtask

  task automatic check(string tag);
    n_cmp++;
    if (o_valid !== x_valid || o_idx !== x_idx || o_key !== x_key) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b idx=%0d key=%h, exp valid=%0b idx=%0d key=%h",
               tag, o_valid, o_idx, o_key, x_valid, x_idx, x_key);
    end
  endtask

  // inputs were set after the previous edge; result is registered at the next
  task automatic step(string tag);
    compute_exp();
    @(posedge clk);
    #2;
    check(tag);
  endtask

  task automatic clear_in();
    bk = 0; ord = 0; ef = 0; es = 0; ec = 0;
    v = 0; sec = 0; car = 0; hi = 0; inn = 0; cor = 0; kv = 0; code = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got running, exp finished");
    summary();
  end

  initial begin
    int it;
    clear_in();
    v = '1; kv = '0; // busy inputs while reset is held
    repeat (3) @(posedge clk);
    #2;
    x_valid = 0; x_idx = 0; x_key = 15'h7FFF;
    check("R1 reset");
    rst_ni = 1'b1;
    clear_in();
    step("R11 none valid");

    // single candidate: ordering x flags x track x carry x enables (R4-R9)
    it = 0;
    for (int o = 0; o < 8; o++)
      for (int f = 0; f < 8; f++)
        for (int t = 0; t < 2; t++)
          for (int c = 0; c < 2; c++)
            for (int e = 0; e < 8; e++) begin
              int s;
              clear_in();
              s = it % N;
              ord = 3'(o);
              v[s] = 1; sec[s] = t[0]; car[s] = c[0];
              hi[s] = f[0]; inn[s] = f[1]; cor[s] = f[2];
              kv[s*6 +: 6] = 6'((it * 7) % 40);
              // wrong enable set would change the key
              ef = ~3'(e); es = ~3'(e); ec = ~3'(e);
              if (c != 0) ec = 3'(e); else if (t != 0) es = 3'(e); else ef = 3'(e);
              if (o >= 6) step("R7 illegal order");
              else if (c != 0) step("R9 carry enables");
              else if (((it * 7) % 40) >= 32) step("R5 K range");
              else if (t != 0) step("R8 second-track enables");
              else step("R6 order / R4 key layout");
              it++;
            end

    // back-up mode codes (R10)
    for (int cd = 0; cd < 8; cd++)
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < N; s++) begin
          clear_in();
          bk = 1; ord = 3'(cd % 6);
          v[s] = 1; sec[s] = t[0]; hi[s] = 1; inn[s] = 1; cor[s] = 1;
          ef = '1; es = '1; ec = '1;
          kv[s*6 +: 6] = 6'(cd * 5 + s);
          code[s*3 +: 3] = 3'(cd);
          step("R10 back-up code");
        end

    // equal keys on all slots: lowest index wins (R3)
    clear_in();
    v = '1; kv = {4{6'd9}}; hi = '1; ef = '1;
    step("R3 full tie");
    v = 4'b1100;
    step("R3 tie upper slots");
    v = 4'b0010; kv[1*6 +: 6] = 6'd40; sec = '1;
    step("R3 lone out-of-range");

    // random groups with frequent ties (R2, R3)
    for (int r = 0; r < 4000; r++) begin
      clear_in();
      bk = 1'($urandom % 5 == 0);
      ord = 3'($urandom % 8);
      ef = 3'($urandom); es = 3'($urandom); ec = 3'($urandom);
      v = 4'($urandom); sec = 4'($urandom); car = 4'($urandom);
      hi = 4'($urandom); inn = 4'($urandom); cor = 4'($urandom);
      for (int s = 0; s < N; s++) begin
        int kk;
        kk = $urandom % 5;
        kv[s*6 +: 6] = (kk == 4) ? 6'd35 : 6'(kk);
        code[s*3 +: 3] = 3'($urandom);
      end
      if (v == 0) step("R2 idle cycle");
      else step("R3 random arbitration");
    end

    clear_in();
    step("R11 idle after traffic");
    summary();
  end
endmodule